// File: doc/BRIEF.md
# Key-Sequence Configuration Port Unlocker

This block is a small slave on an 8-bit port-mapped host bus. It keeps an adapter switched off after reset and wakes it only when the host writes a fixed five-byte key: the first byte goes to one I/O address and the next four go to a second address. The next write to the second address is taken as a packed configuration byte. That byte sets the enable flag, picks the adapter's base address from an eight-entry table, and sets a three-bit interrupt-line code.

While the adapter is enabled it decodes a 16-byte window at the selected base. Offset 9 of the window holds a wake-up status register. Software writes 0xC0 there and reads back 0x80 to confirm that the adapter responded. The key bytes, the two key port addresses and the base table variant are parameters, so one design serves boards with a different key or address table. A fresh key followed by a new configuration byte moves or disables an adapter that is already running.

Top module: `cfg_key_unlock`

## Requirements
- R1: After reset en_o is 0, irq_o is 0, base_o is the table entry for index 0, and every read returns 0xFF.
- R2: The writes 0x59 to address 0x779, then 0xB9, 0xC5, 0xAE and 0xA6 to address 0x379, followed by a configuration byte written to 0x379, load that byte on the clock edge of its write: bit 7 goes to en_o, bits 6:4 go to irq_o, and bits 2:0 select the table index.
- R3: A key write to either key port whose value differs from the expected key byte sends the sequencer back to its start. Later bytes then have no effect until the key is restarted at its first byte.
- R4: A key byte written to the wrong key port (the first byte anywhere but 0x779, or any later byte anywhere but 0x379) sends the sequencer back to its start.
- R5: A configuration byte of 0x00 after a complete key leaves en_o at 0.
- R6: With TABLE_VAR=0, index 0..7 selects base 0x280, 0x290, 0x300, 0x310, 0x330, 0x340, 0x348, 0x350. With TABLE_VAR=1 it selects 0x220, 0x240, 0x280, 0x2A0, 0x2C0, 0x300, 0x320, 0x340.
- R7: A read returns 0xFF when the adapter is disabled or the address lies outside [base_o, base_o+15]. Inside the window, reads of any offset other than 9 return 0x00.
- R8: A write to base_o+9 stores data bit 7 as a status flag. A read of base_o+9 returns the flag in bit 7 with bits 6:0 at zero, so writing 0xC0 reads back 0x80 and writing 0x00 reads back 0x00.
- R9: A new key on an enabled adapter leaves en_o, irq_o and base_o unchanged until the configuration byte is written. They change only on configuration writes.
- R10: Writes to addresses other than the two key ports leave the sequencer position unchanged, so a key can be completed around them.
- R11: The KEY parameter replaces the key: an instance built with key 0x0F, 0x22, 0xF0, 0x20, 0x80 accepts that sequence and ignores the default key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | I/O address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address and strobe |
| en_o | output | 1 | Adapter enable |
| base_o | output | ADDR_W | Selected base address |
| irq_o | output | 3 | Interrupt-line code |

## Verification
The bench goes after a key broken by a wrong value, and after a key broken by a right value sent to the wrong port. A sequencer that only compared data, or that resynchronised mid-key, would then accept the trailing configuration byte and move the adapter. It completes a key with unrelated and in-window writes placed between key bytes, which catches a sequencer that resets on any write. It checks that a key already in progress leaves the old base in place until the configuration byte arrives, and that a zero byte disables the adapter. On the window it probes the last byte inside and the first byte on each side of it, and it checks that the status bit reads back masked. A second instance with the alternate key and table shows that the default key is refused there.

// File: rtl/cku_pkg.sv
package cku_pkg;

  typedef struct packed {
    logic       en;
    logic [2:0] irq;
    logic [2:0] idx;
  } cfg_t;

  function automatic logic [11:0] base_tab_a(input logic [2:0] idx);
    case (idx)
      3'd0: return 12'h280;
      3'd1: return 12'h290;
      3'd2: return 12'h300;
      3'd3: return 12'h310;
      3'd4: return 12'h330;
      3'd5: return 12'h340;
      3'd6: return 12'h348;
      default: return 12'h350;
    endcase
  endfunction

  function automatic logic [11:0] base_tab_b(input logic [2:0] idx);
    case (idx)
      3'd0: return 12'h220;
      3'd1: return 12'h240;
      3'd2: return 12'h280;
      3'd3: return 12'h2A0;
      3'd4: return 12'h2C0;
      3'd5: return 12'h300;
      3'd6: return 12'h320;
      default: return 12'h340;
    endcase
  endfunction

endpackage

// File: rtl/cku_key_seq.sv
module cku_key_seq #(
  parameter int                  ADDR_W     = 16,
  parameter int                  KEY_LEN    = 5,
  parameter logic [KEY_LEN*8-1:0] KEY       = 40'h59_B9_C5_AE_A6,
  parameter logic [ADDR_W-1:0]   FIRST_PORT = 16'h0779,
  parameter logic [ADDR_W-1:0]   NEXT_PORT  = 16'h0379,
  localparam int                 POS_W      = $clog2(KEY_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              cfg_wr_o,
  output logic [POS_W-1:0]  pos_o
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [7:0]       exp_byte;
  logic             at_first, at_next;

  assign at_first = (addr_i == FIRST_PORT);
  assign at_next  = (addr_i == NEXT_PORT);

  always_comb begin
    exp_byte = '0;
    for (int i = 0; i < KEY_LEN; i++)
      if (pos_q == POS_W'(i)) exp_byte = KEY[(KEY_LEN-1-i)*8 +: 8];
  end

  always_comb begin
    pos_d    = pos_q;
    cfg_wr_o = 1'b0;
    if (wr_i && (at_first || at_next)) begin
      if (pos_q == POS_W'(KEY_LEN)) begin
        cfg_wr_o = at_next;
        pos_d    = '0;
      end else if (pos_q == '0) begin
        pos_d = (at_first && wdata_i == exp_byte) ? POS_W'(1) : '0;
      end else begin
        pos_d = (at_next && wdata_i == exp_byte) ? pos_q + POS_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;

  assign pos_o = pos_q;

endmodule

// File: rtl/cku_base_lut.sv
module cku_base_lut #(
  parameter int ADDR_W    = 16,
  parameter int TABLE_VAR = 0
) (
  input  logic [2:0]        idx_i,
  output logic [ADDR_W-1:0] base_o
);

  generate
    if (TABLE_VAR == 0) begin : g_tab_a
      assign base_o = ADDR_W'(cku_pkg::base_tab_a(idx_i));
    end else begin : g_tab_b
      assign base_o = ADDR_W'(cku_pkg::base_tab_b(idx_i));
    end
  endgenerate

endmodule

// File: rtl/cku_win_port.sv
module cku_win_port #(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 16,
  parameter int STAT_OFF  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbit_i,
  output logic [7:0]        rdata_o
);

  logic [ADDR_W-1:0] off;
  logic              in_win, at_stat, alive_q;

  assign off     = addr_i - base_i;
  assign in_win  = en_i && (addr_i >= base_i) && (off < ADDR_W'(WIN_BYTES));
  assign at_stat = in_win && (off == ADDR_W'(STAT_OFF));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               alive_q <= 1'b0;
    else if (wr_i && at_stat)  alive_q <= wbit_i;

  always_comb begin
    if (!(rd_i && in_win)) rdata_o = 8'hFF;
    else if (at_stat)      rdata_o = {alive_q, 7'b0};
    else                   rdata_o = 8'h00;
  end

endmodule

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock #(
  parameter int                   ADDR_W     = 16,
  parameter int                   KEY_LEN    = 5,
  parameter logic [KEY_LEN*8-1:0] KEY        = 40'h59_B9_C5_AE_A6,
  parameter logic [ADDR_W-1:0]    FIRST_PORT = 16'h0779,
  parameter logic [ADDR_W-1:0]    NEXT_PORT  = 16'h0379,
  parameter int                   TABLE_VAR  = 0,
  parameter int                   WIN_BYTES  = 16,
  parameter int                   STAT_OFF   = 9,
  localparam int                  POS_W      = $clog2(KEY_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              en_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [2:0]        irq_o
);

  cku_pkg::cfg_t    cfg_q;
  logic             cfg_wr;
  logic [POS_W-1:0] seq_pos;

  cku_key_seq #(
    .ADDR_W(ADDR_W), .KEY_LEN(KEY_LEN), .KEY(KEY),
    .FIRST_PORT(FIRST_PORT), .NEXT_PORT(NEXT_PORT)
  ) u_seq (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .cfg_wr_o(cfg_wr), .pos_o(seq_pos)
  );

  // packed config byte: [7] enable, [6:4] irq code, [2:0] table index
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_wr) cfg_q <= '{en: wdata_i[7], irq: wdata_i[6:4], idx: wdata_i[2:0]};

  cku_base_lut #(.ADDR_W(ADDR_W), .TABLE_VAR(TABLE_VAR)) u_lut (
    .idx_i(cfg_q.idx), .base_o(base_o)
  );

  cku_win_port #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .STAT_OFF(STAT_OFF)) u_win (
    .clk_i, .rst_ni, .en_i(cfg_q.en), .base_i(base_o), .wr_i, .rd_i, .addr_i,
    .wbit_i(wdata_i[7]), .rdata_o(rdata_o)
  );

  assign en_o  = cfg_q.en;
  assign irq_o = cfg_q.irq;

endmodule

// File: rtl/cku_chk.sv
module cku_chk #(
  parameter int                   ADDR_W     = 16,
  parameter int                   KEY_LEN    = 5,
  parameter logic [KEY_LEN*8-1:0] KEY        = 40'h59_B9_C5_AE_A6,
  parameter logic [ADDR_W-1:0]    FIRST_PORT = 16'h0779,
  parameter logic [ADDR_W-1:0]    NEXT_PORT  = 16'h0379,
  parameter int                   STAT_OFF   = 9,
  parameter int                   POS_W      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              en_o,
  input logic [ADDR_W-1:0] base_o,
  input logic [2:0]        irq_o,
  input logic              cfg_wr,
  input logic [POS_W-1:0]  seq_pos
);

  localparam logic [7:0] KEY0 = KEY[KEY_LEN*8-1 -: 8];

  AST_CFG_EN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> en_o == $past(wdata_i[7])); // R2

  AST_BAD_FIRST_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == FIRST_PORT && wdata_i != KEY0) |=> seq_pos == '0); // R3

  AST_ZERO_CFG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && wdata_i == 8'h00) |=> !en_o); // R5

  AST_DISABLED_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> rdata_o == 8'hFF); // R7

  AST_STAT_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && rd_i && addr_i == base_o + ADDR_W'(STAT_OFF)) |-> rdata_o[6:0] == 7'd0); // R8

  AST_CFG_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({en_o, irq_o, base_o}) |-> $past(cfg_wr)); // R9

  AST_FOREIGN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != FIRST_PORT && addr_i != NEXT_PORT) |=> seq_pos == $past(seq_pos)); // R10

endmodule

bind cfg_key_unlock cku_chk #(
  .ADDR_W(ADDR_W), .KEY_LEN(KEY_LEN), .KEY(KEY), .FIRST_PORT(FIRST_PORT),
  .NEXT_PORT(NEXT_PORT), .STAT_OFF(STAT_OFF), .POS_W(POS_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .en_o(en_o), .base_o(base_o),
  .irq_o(irq_o), .cfg_wr(cfg_wr), .seq_pos(seq_pos)
);

// File: tb/sim_cfg_key_unlock.sv
module sim_cfg_key_unlock;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata0, rdata1;
  logic        en0, en1;
  logic [15:0] base0, base1;
  logic [2:0]  irq0, irq1;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cfg_key_unlock u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata0), .en_o(en0), .base_o(base0), .irq_o(irq0)
  );

  cfg_key_unlock #(.KEY(40'h0F_22_F0_20_80), .TABLE_VAR(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata1), .en_o(en1), .base_o(base1), .irq_o(irq1)
  );

  // {op, tag, addr, data}; op 0=write, 1=read expect data, 2=check base=addr, {en,irq}=data[7:4]
  localparam int NV = 58;
  localparam logic [29:0] VEC [NV] = '{
    {2'd2, 4'd1,  16'h0280, 8'h00},  // R1 reset state
    {2'd1, 4'd1,  16'h0289, 8'hFF},  // R1 reads FF
    {2'd0, 4'd2,  16'h0779, 8'h59},  // R2 key
    {2'd0, 4'd2,  16'h0379, 8'hB9},
    {2'd0, 4'd2,  16'h0379, 8'hC5},
    {2'd0, 4'd2,  16'h0379, 8'hAE},
    {2'd0, 4'd2,  16'h0379, 8'hA6},
    {2'd0, 4'd2,  16'h0379, 8'h95},
    {2'd2, 4'd2,  16'h0340, 8'h90},  // R2 en, irq 1, idx 5
    {2'd1, 4'd8,  16'h0349, 8'h00},  // R8
    {2'd0, 4'd8,  16'h0349, 8'hC0},
    {2'd1, 4'd8,  16'h0349, 8'h80},  // R8 wake readback
    {2'd1, 4'd7,  16'h0340, 8'h00},  // R7 other offset
    {2'd1, 4'd7,  16'h034F, 8'h00},  // R7 last byte in
    {2'd1, 4'd7,  16'h0350, 8'hFF},  // R7 above window
    {2'd1, 4'd7,  16'h033F, 8'hFF},  // R7 below window
    {2'd0, 4'd8,  16'h0349, 8'h00},
    {2'd1, 4'd8,  16'h0349, 8'h00},  // R8 cleared
    {2'd0, 4'd3,  16'h0779, 8'h59},  // R3 wrong value
    {2'd0, 4'd3,  16'h0379, 8'hB9},
    {2'd0, 4'd3,  16'h0379, 8'hC4},
    {2'd0, 4'd3,  16'h0379, 8'hAE},
    {2'd0, 4'd3,  16'h0379, 8'hA6},
    {2'd0, 4'd3,  16'h0379, 8'h82},
    {2'd2, 4'd3,  16'h0340, 8'h90},  // R3 unchanged
    {2'd0, 4'd4,  16'h0779, 8'h59},  // R4 wrong port
    {2'd0, 4'd4,  16'h0779, 8'hB9},
    {2'd0, 4'd4,  16'h0379, 8'hC5},
    {2'd0, 4'd4,  16'h0379, 8'hAE},
    {2'd0, 4'd4,  16'h0379, 8'hA6},
    {2'd0, 4'd4,  16'h0379, 8'h82},
    {2'd2, 4'd4,  16'h0340, 8'h90},  // R4 unchanged
    {2'd0, 4'd10, 16'h0779, 8'h59},  // R10 foreign writes mid-key
    {2'd0, 4'd10, 16'h0379, 8'hB9},
    {2'd0, 4'd10, 16'h0100, 8'hAA},
    {2'd0, 4'd10, 16'h0341, 8'h55},
    {2'd0, 4'd10, 16'h0379, 8'hC5},
    {2'd0, 4'd10, 16'h0379, 8'hAE},
    {2'd0, 4'd10, 16'h0379, 8'hA6},
    {2'd0, 4'd10, 16'h0379, 8'hE7},
    {2'd2, 4'd10, 16'h0350, 8'hE0},  // R10 / R6 idx 7
    {2'd0, 4'd9,  16'h0779, 8'h59},  // R9 reconfigure
    {2'd0, 4'd9,  16'h0379, 8'hB9},
    {2'd0, 4'd9,  16'h0379, 8'hC5},
    {2'd0, 4'd9,  16'h0379, 8'hAE},
    {2'd0, 4'd9,  16'h0379, 8'hA6},
    {2'd2, 4'd9,  16'h0350, 8'hE0},  // R9 old settings hold
    {2'd0, 4'd9,  16'h0379, 8'h80},
    {2'd2, 4'd9,  16'h0280, 8'h80},  // R9 new base idx 0
    {2'd1, 4'd9,  16'h0289, 8'h00},
    {2'd0, 4'd5,  16'h0779, 8'h59},  // R5 zero config
    {2'd0, 4'd5,  16'h0379, 8'hB9},
    {2'd0, 4'd5,  16'h0379, 8'hC5},
    {2'd0, 4'd5,  16'h0379, 8'hAE},
    {2'd0, 4'd5,  16'h0379, 8'hA6},
    {2'd0, 4'd5,  16'h0379, 8'h00},
    {2'd2, 4'd5,  16'h0280, 8'h00},  // R5 disabled
    {2'd1, 4'd5,  16'h0289, 8'hFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic bus_rd(input string tag, input logic [15:0] a, input logic [7:0] exp, input bit use_u1);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #2;
    check(tag, use_u1 ? rdata1 : rdata0, exp);
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic cfg_chk(input string tag, input bit use_u1, input logic [15:0] b, input logic [3:0] ei);
    @(negedge clk); #1;
    if (use_u1) check(tag, {base1, en1, irq1}, {b, ei});
    else        check(tag, {base0, en0, irq0}, {b, ei});
  endtask

  task automatic send_key(input logic [39:0] k, input logic [7:0] cfg);
    bus_wr(16'h0779, k[39:32]);
    bus_wr(16'h0379, k[31:24]);
    bus_wr(16'h0379, k[23:16]);
    bus_wr(16'h0379, k[15:8]);
    bus_wr(16'h0379, k[7:0]);
    bus_wr(16'h0379, cfg);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  tg;
      logic [15:0] a;
      logic [7:0]  d;
      {op, tg, a, d} = VEC[i];
      case (op)
        2'd0: bus_wr(a, d);
        2'd1: bus_rd($sformatf("R%0d vec %0d rdata", tg, i), a, d, 1'b0);
        default: cfg_chk($sformatf("R%0d vec %0d base/en/irq", tg, i), 1'b0, a, d[7:4]);
      endcase
    end

    // R1: reset while enabled
    send_key(40'h59_B9_C5_AE_A6, 8'hF3);
    cfg_chk("R6 idx 3 table A", 1'b0, 16'h0310, 4'hF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 reset clears", {base0, en0, irq0}, {16'h0280, 4'h0});
    rst_n = 1'b1;
    bus_rd("R1 read after reset", 16'h0319, 8'hFF, 1'b0);

    // R11: alternate key on u1, table variant B
    send_key(40'h0F_22_F0_20_80, 8'hA3);
    cfg_chk("R11 alt key accepted", 1'b1, 16'h02A0, 4'hA);
    bus_wr(16'h02A9, 8'hC0);
    bus_rd("R8 u1 wake readback", 16'h02A9, 8'h80, 1'b1);
    send_key(40'h59_B9_C5_AE_A6, 8'h85);
    cfg_chk("R11 default key refused", 1'b1, 16'h02A0, 4'hA);
    send_key(40'h0F_22_F0_20_80, 8'h87);
    cfg_chk("R6 idx 7 table B", 1'b1, 16'h0340, 4'h8);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule